// File: doc/BRIEF.md
# Time-Division Stereo Channel Output Multiplexer

This block sits between a six-voice FM synthesis core and the stereo converter. Each voice delivers a signed 14-bit result. The block does not add the voices together. It visits them one at a time in a fixed loop and drives a single shared left/right output pair. Each visit is one slot, and a slot is marked by a one-cycle slot enable. During its slot a voice is reduced to 9 bits by dropping its low bits. Dropping bits from a two's complement value rounds towards minus infinity. This leaves negative values one step lower than their positive mirror images, which gives the familiar step distortion on the negative half of a waveform.

Every voice has two pan bits, one for the left side and one for the right side. Setting both bits centres the voice. Clearing both silences it during its slot. The last voice, index 5, can be switched to a host-written 8-bit PCM byte through a DAC-enable control. The byte is held in a host register. The block applies no sample timing and keeps no buffer for it. A build parameter turns the reduction off, so that the outputs carry the full 14-bit value for comparison.

Top module: `fm_slot_mux`

## Requirements
- R1: While reset is low and after it is released, `left_out`, `right_out` and `ch_idx` are 0 until the first slot enable.
- R2: Each cycle with `slot_en` high loads the output registers with the voice at the internal pointer and sets `ch_idx` to that voice. The pointer then advances 0,1,2,3,4,5,0,… Reset sets the pointer to 0, so the first slot after reset shows voice 0.
- R3: In cycles with `slot_en` low, `left_out`, `right_out` and `ch_idx` keep their values.
- R4: With the default reduction, the 9-bit output of an FM voice is floor(x / 32) of its signed 14-bit value x. Voice i occupies `ch_data[14*i+13 : 14*i]`. Only the voice at the pointer reaches the outputs, and nothing is summed.
- R5: The reduction is asymmetric. Inputs 0 to 31 give 0, inputs -1 to -32 give -1 (0x1FF), and -33 gives -2 (0x1FE).
- R6: `pan_l[i]` routes voice i to `left_out` and `pan_r[i]` routes it to `right_out`. With both bits set, the two outputs are equal.
- R7: A voice with both pan bits clear drives 0 on both outputs during its slot.
- R8: With `dac_en` high, the slot of voice 5 carries the PCM byte instead of its FM value, still under its pan bits. Slots of voices 0 to 4 are unaffected.
- R9: The PCM byte is offset-binary. The output is (byte - 128) * 2 as a 9-bit two's complement value: 0x80 gives 0x000, 0x00 gives 0x100, and 0xFF gives 0x0FE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_en | input | 1 | One-cycle strobe that starts the next voice slot |
| ch_data | input | 84 | Six signed 14-bit voice results, voice i in bits 14*i+13..14*i |
| pan_l | input | 6 | Per-voice left enable |
| pan_r | input | 6 | Per-voice right enable |
| dac_en | input | 1 | Replace voice 5 by the PCM byte |
| pcm_byte | input | 8 | Host PCM sample, offset-binary |
| left_out | output | 9 | Left sample for the current slot |
| right_out | output | 9 | Right sample for the current slot |
| ch_idx | output | 3 | Voice shown on the outputs |

## Verification
Each result is registered exactly once. The values present when `slot_en` is high therefore appear on `left_out`, `right_out` and `ch_idx` after the next rising edge, and they stay there until the next slot enable. The bench drives inputs on the falling edge and raises `slot_en` for one cycle. It compares the outputs on the following falling edge against values it computes from the requirements. It keeps its own copy of the pointer. During idle gaps it compares the outputs at every falling edge against the last slot's values.

// File: rtl/fmx_pkg.sv
// Package: shared definitions for the slot multiplexer.
// Assumes: used by all fmx_* modules and by fm_slot_mux.
package fmx_pkg;

    // Source of the value presented in a slot.
    typedef enum logic {
        SRC_FM  = 1'b0,
        SRC_PCM = 1'b1
    } src_e;

    // Output width for a given reduction choice.
    function automatic int slot_width(int in_w, int out_w, bit reduce);
        return reduce ? out_w : in_w;
    endfunction

endpackage

// File: rtl/fmx_slot_ctr.sv
// Module: fmx_slot_ctr
// Rotating slot pointer. It steps once per strobe and wraps from
// NUM_CH-1 to 0.
// Assumes: NUM_CH >= 2 and IDX_W wide enough to hold NUM_CH-1.
module fmx_slot_ctr #(
    parameter int NUM_CH = 6,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

    // Advance the pointer on each strobe, wrapping at the last voice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/fmx_reduce.sv
// Module: fmx_reduce
// Cuts a signed voice word down to the output width by dropping
// low bits, which rounds towards minus infinity. With equal widths
// the word passes through unchanged.
// Assumes: OW <= IN_W.
module fmx_reduce #(
    parameter int IN_W = 14,
    parameter int OW   = 9
) (
    input  logic [IN_W-1:0] din,
    output logic [OW-1:0]   dout
);

    generate
        if (OW < IN_W) begin : g_cut
            // Keep the top OW bits (arithmetic floor division).
            assign dout = din[IN_W-1 -: OW];
        end else begin : g_pass
            // Full-precision pass-through.
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/fmx_pcm_fmt.sv
// Module: fmx_pcm_fmt
// Converts an offset-binary PCM byte to two's complement and places
// it in the top bits of the output word.
// Assumes: OW > PCM_W.
module fmx_pcm_fmt #(
    parameter int PCM_W = 8,
    parameter int OW    = 9
) (
    input  logic [PCM_W-1:0] pcm,
    output logic [OW-1:0]    dout
);

    localparam int PAD = OW - PCM_W;

    // Invert the sign bit, then pad with zeros below.
    assign dout = {~pcm[PCM_W-1], pcm[PCM_W-2:0], {PAD{1'b0}}};

endmodule

// File: rtl/fm_slot_mux.sv
// Module: fm_slot_mux (top)
// Time-division stereo output multiplexer. Each slot enable shows one
// voice on the left/right pair, gated by its pan bits. The last voice
// (PCM_CH) may be replaced by a host PCM byte. Voices are not summed.
// Assumes: slot_en is a one-cycle strobe. The PCM byte is held
// stable by the host. Reset is synchronous and active low.
module fm_slot_mux
    import fmx_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int IN_W   = 14,
    parameter int OUT_W  = 9,
    parameter int PCM_W  = 8,
    parameter bit REDUCE = 1'b1,
    parameter int PCM_CH = NUM_CH - 1,
    localparam int OW    = slot_width(IN_W, OUT_W, REDUCE),
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   slot_en,
    input  logic [NUM_CH*IN_W-1:0] ch_data,
    input  logic [NUM_CH-1:0]      pan_l,
    input  logic [NUM_CH-1:0]      pan_r,
    input  logic                   dac_en,
    input  logic [PCM_W-1:0]       pcm_byte,
    output logic [OW-1:0]          left_out,
    output logic [OW-1:0]          right_out,
    output logic [IDX_W-1:0]       ch_idx
);

    logic [IDX_W-1:0] ptr;
    logic [OW-1:0]    reduced [NUM_CH];
    logic [OW-1:0]    pcm_word;
    logic [OW-1:0]    slot_val;
    src_e             src;

    // Slot pointer.
    fmx_slot_ctr #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (slot_en),
        .ptr   (ptr)
    );

    // One reducer per voice.
    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_red
            fmx_reduce #(
                .IN_W (IN_W),
                .OW   (OW)
            ) u_red (
                .din  (ch_data[i*IN_W +: IN_W]),
                .dout (reduced[i])
            );
        end
    endgenerate

    // PCM byte formatter.
    fmx_pcm_fmt #(
        .PCM_W (PCM_W),
        .OW    (OW)
    ) u_pcm (
        .pcm  (pcm_byte),
        .dout (pcm_word)
    );

    // Pick the source of the current slot.
    always_comb begin
        src = (dac_en && ptr == IDX_W'(PCM_CH)) ? SRC_PCM : SRC_FM;
    end

    // Select the one value that drives this slot.
    always_comb begin
        slot_val = (src == SRC_PCM) ? pcm_word : reduced[ptr];
    end

    // Register the panned slot value and its voice index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_out  <= '0;
            right_out <= '0;
            ch_idx    <= '0;
        end else if (slot_en) begin
            left_out  <= pan_l[ptr] ? slot_val : '0;
            right_out <= pan_r[ptr] ? slot_val : '0;
            ch_idx    <= ptr;
        end
    end

endmodule

// File: rtl/fm_slot_mux_chk.sv
// Module: fm_slot_mux_chk
// Assertion checker for fm_slot_mux, attached through bind below.
// Assumes: the same parameters as the bound instance.
module fm_slot_mux_chk #(
    parameter int NUM_CH = 6,
    parameter int OW     = 9,
    parameter int PCM_W  = 8,
    parameter int PCM_CH = NUM_CH - 1,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_en,
    input logic [NUM_CH-1:0] pan_l,
    input logic [NUM_CH-1:0] pan_r,
    input logic              dac_en,
    input logic [PCM_W-1:0]  pcm_byte,
    input logic [OW-1:0]     left_out,
    input logic [OW-1:0]     right_out,
    input logic [IDX_W-1:0]  ch_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

    logic              seen;
    logic [NUM_CH-1:0] pl_q;
    logic [NUM_CH-1:0] pr_q;
    logic              dac_q;
    logic [PCM_W-1:0]  pcm_q;
    logic [OW-1:0]     pcm_exp;

    // Keep a one-cycle copy of the inputs and whether any slot has run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen  <= 1'b0;
            pl_q  <= '0;
            pr_q  <= '0;
            dac_q <= 1'b0;
            pcm_q <= '0;
        end else begin
            pl_q  <= pan_l;
            pr_q  <= pan_r;
            dac_q <= dac_en;
            pcm_q <= pcm_byte;
            if (slot_en) seen <= 1'b1;
        end
    end

    // Expected signed, left-aligned form of the captured PCM byte.
    always_comb begin
        pcm_exp = {~pcm_q[PCM_W-1], pcm_q[PCM_W-2:0], {(OW-PCM_W){1'b0}}};
    end

    p_first_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en && !seen |=> ch_idx == '0);

    p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en && seen |=>
        ch_idx == (($past(ch_idx) == LAST) ? '0 : $past(ch_idx) + 1'b1));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> $stable(left_out) && $stable(right_out) && $stable(ch_idx));

    p_centre_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en |=> !(pl_q[ch_idx] && pr_q[ch_idx]) || left_out == right_out);

    p_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en |=> (pl_q[ch_idx] || left_out == '0) && (pr_q[ch_idx] || right_out == '0));

    p_pcm_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en |=> !(dac_q && ch_idx == IDX_W'(PCM_CH) && pl_q[ch_idx])
                    || left_out == pcm_exp);

endmodule

bind fm_slot_mux fm_slot_mux_chk #(
    .NUM_CH (NUM_CH),
    .OW     (OW),
    .PCM_W  (PCM_W),
    .PCM_CH (PCM_CH),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_en   (slot_en),
    .pan_l     (pan_l),
    .pan_r     (pan_r),
    .dac_en    (dac_en),
    .pcm_byte  (pcm_byte),
    .left_out  (left_out),
    .right_out (right_out),
    .ch_idx    (ch_idx)
);

// File: tb/sim_fm_slot_mux.sv
// Bench for fm_slot_mux: directed corner cases plus seeded random slots.
module sim_fm_slot_mux;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_en = 1'b0;
    logic [83:0] ch_data = '0;
    logic [5:0]  pan_l = '0;
    logic [5:0]  pan_r = '0;
    logic        dac_en = 1'b0;
    logic [7:0]  pcm_byte = 8'h80;
    logic [8:0]  left_out;
    logic [8:0]  right_out;
    logic [2:0]  ch_idx;

    int checks = 0;
    int failures = 0;
    int exp_ptr = 0;
    logic [8:0] last_l = '0;
    logic [8:0] last_r = '0;
    logic [2:0] last_i = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fm_slot_mux u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_en   (slot_en),
        .ch_data   (ch_data),
        .pan_l     (pan_l),
        .pan_r     (pan_r),
        .dac_en    (dac_en),
        .pcm_byte  (pcm_byte),
        .left_out  (left_out),
        .right_out (right_out),
        .ch_idx    (ch_idx)
    );

    // Compare one value and report a failure.
    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Store a signed voice value.
    task automatic set_ch(int i, int v);
        ch_data[i*14 +: 14] = 14'(v);
    endtask

    // Floor(x/32) of a signed 14-bit value, as 9 bits.
    function automatic logic [8:0] fm_exp(int v14);
        int s;
        int q;
        s = (v14 >= 8192) ? v14 - 16384 : v14;
        q = (s >= 0) ? s / 32 : -((-s + 31) / 32);
        return 9'(q);
    endfunction

    // (byte - 128) * 2 as 9 bits.
    function automatic logic [8:0] pcm_exp(logic [7:0] b);
        return 9'((int'(b) - 128) * 2);
    endfunction

    // Value expected for a voice under current inputs.
    function automatic logic [8:0] voice_exp(int ch);
        if (ch == 5 && dac_en) return pcm_exp(pcm_byte);
        return fm_exp(int'(ch_data[ch*14 +: 14]));
    endfunction

    // Issue one slot and check index and both outputs.
    task automatic do_slot(string tag);
        logic [8:0] v;
        logic [8:0] el;
        logic [8:0] er;
        v  = voice_exp(exp_ptr);
        el = pan_l[exp_ptr] ? v : 9'd0;
        er = pan_r[exp_ptr] ? v : 9'd0;
        slot_en = 1'b1;
        @(negedge clk);
        slot_en = 1'b0;
        check("R2 ch_idx", int'(ch_idx), exp_ptr);
        check({tag, " left"}, int'(left_out), int'(el));
        check({tag, " right"}, int'(right_out), int'(er));
        last_l = left_out;
        last_r = right_out;
        last_i = ch_idx;
        exp_ptr = (exp_ptr == 5) ? 0 : exp_ptr + 1;
    endtask

    // Idle cycles with outputs held.
    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check("R3 hold left", int'(left_out), int'(last_l));
            check("R3 hold right", int'(right_out), int'(last_r));
            check("R3 hold idx", int'(ch_idx), int'(last_i));
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Main sequence.
    initial begin
        int unsigned seed;
        seed = $urandom(32'h1A2B3C);
        repeat (3) @(negedge clk);
        check("R1 reset left", int'(left_out), 0);
        check("R1 reset right", int'(right_out), 0);
        check("R1 reset idx", int'(ch_idx), 0);
        rst_n = 1'b1;
        pan_l = 6'h3F;
        pan_r = 6'h3F;
        set_ch(0, 1000);
        @(negedge clk);
        check("R1 idle after reset", int'(left_out), 0);

        // R4/R5: reduction corners, centred pan (R6)
        set_ch(0, 31);
        set_ch(1, -1);
        set_ch(2, -32);
        set_ch(3, -33);
        set_ch(4, 8191);
        set_ch(5, -8192);
        do_slot("R5 +31");
        check("R5 +31 is 0", int'(last_l), 0);
        do_slot("R5 -1");
        check("R5 -1 is 0x1FF", int'(last_l), 'h1FF);
        do_slot("R5 -32");
        do_slot("R5 -33");
        check("R5 -33 is 0x1FE", int'(last_l), 'h1FE);
        do_slot("R4 max");
        check("R4 max is 0x0FF", int'(last_l), 'h0FF);
        do_slot("R4 min");
        check("R4 min is 0x100", int'(last_l), 'h100);
        check("R2 wrap pointer", exp_ptr, 0);
        idle(3);

        // R6/R7: pan routing
        for (int i = 0; i < 6; i++) set_ch(i, 2000 + 640 * i);
        pan_l = 6'b000101;
        pan_r = 6'b000011;
        do_slot("R6 both");
        do_slot("R6 right only");
        check("R6 left gated", int'(last_l), 0);
        do_slot("R6 left only");
        check("R6 right gated", int'(last_r), 0);
        do_slot("R7 none");
        check("R7 none left", int'(last_l), 0);
        check("R7 none right", int'(last_r), 0);
        pan_l = 6'h3F;
        pan_r = 6'h3F;
        do_slot("R6 all");

        // R8/R9: PCM replaces voice 5
        dac_en = 1'b1;
        pcm_byte = 8'h00;
        do_slot("R8 pcm");
        check("R9 0x00 gives 0x100", int'(last_l), 'h100);
        do_slot("R8 voice0 unaffected");
        check("R8 voice0 FM", int'(last_l), int'(fm_exp(2000)));
        for (int i = 0; i < 4; i++) do_slot("R8 fm");
        pcm_byte = 8'h80;
        do_slot("R9 0x80");
        check("R9 0x80 gives 0", int'(last_l), 0);
        for (int i = 0; i < 5; i++) do_slot("R8 fm");
        pcm_byte = 8'hFF;
        pan_l = 6'b011111;
        do_slot("R8 pcm right");
        check("R9 0xFF gives 0x0FE", int'(last_r), 'h0FE);
        check("R8 pcm panned off", int'(last_l), 0);
        dac_en = 1'b0;
        for (int i = 0; i < 5; i++) do_slot("R4 fm");
        do_slot("R8 off gives FM");
        check("R8 dac off", int'(last_r), int'(fm_exp(2000 + 640 * 5)));

        // Seeded random slots with random gaps.
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < 6; i++) set_ch(i, int'($urandom_range(0, 16383)));
            pan_l = 6'($urandom);
            pan_r = 6'($urandom);
            dac_en = 1'($urandom);
            pcm_byte = 8'($urandom);
            do_slot("R6 random");
            idle(int'($urandom_range(0, 2)));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule